// File: doc/BRIEF.md
# Floppy Data Rate and Write Precompensation Control

This block holds the write-only rate-and-precompensation control byte of a floppy disk controller. It also produces the write-precompensation delay, counted in reference-clock ticks, that the write-data path applies. A host write to the control byte sets four things: a 2-bit data-rate code, a 3-bit precompensation code, a power-down flag and a software-reset request. A second write port, the configuration-control path, can also set the data rate. The rate code in force is the one from whichever port wrote last.

The delay is looked up from the precompensation code and the rate in force. At the highest rate the step is half as long. The delay is applied only on tracks at or above a programmable start track, and never while power-down is set. The reference clock is 48 MHz, so one tick is about 20.83 ns. The request bit produces a one-cycle software-reset pulse for the surrounding controller logic. It is never kept as stored state.

Top module: `fdc_rate_precomp`

## Requirements
- R1: After hardware reset the control byte reads as 02h: rate code 2'b10 (250 Kbps), precompensation code 3'b000, power-down 0, no reset pulse. The start track is 0.
- R2: A control-byte write stores bits 1:0 as the rate code, bits 4:2 as the precompensation code and bit 6 as power-down. The value of bit 5 has no effect on any output.
- R3: A configuration-control write changes only the rate code. The rate code follows the most recent write of either port. When both ports write in the same cycle, the control-byte value wins. With no write, the rate code holds.
- R4: A control-byte write with bit 7 set raises the reset pulse for exactly the one cycle after the write. The stored rate code, precompensation code and power-down flag stay as that write set them, before and after the pulse.
- R5: For rate codes 00, 01 and 10 (below 2 Mbps), precompensation code n in 1..6 gives 2n ticks, code 7 gives 0 ticks and code 0 gives 6 ticks.
- R6: For rate code 11 (2 Mbps), code n in 1..6 gives n ticks, code 7 gives 0 ticks and code 0 gives 2 ticks.
- R7: The delay is 0 while the current track is below the start track. It follows R5 or R6 when the current track equals or exceeds the start track.
- R8: While power-down is set, the delay is 0 for every code and rate.
- R9: A configure write loads the start track. The start track keeps that value until the next configure write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| dsr_we | input | 1 | Control-byte write strobe |
| dsr_wdata | input | 8 | Control-byte write data |
| ccr_we | input | 1 | Configuration-control rate write strobe |
| ccr_rate | input | 2 | Rate code from the configuration-control port |
| cfg_we | input | 1 | Configure-command start-track write strobe |
| cfg_start_trk | input | 8 | New start track |
| cur_trk | input | 8 | Track currently being written |
| rate_sel | output | 2 | Rate code in force |
| precomp_code | output | 3 | Stored precompensation code |
| power_down | output | 1 | Stored power-down flag |
| soft_rst_pulse | output | 1 | One-cycle software-reset pulse |
| precomp_ticks | output | 4 | Write precompensation delay in reference ticks |

## Verification
All stored state is visible at the ports, either directly or through the delay lookup. A wrong rate code or precompensation code shows up as a wrong tick count in the cycle right after the write that set it. A lost power-down flag or a wrong start track shows up as a nonzero delay where zero is due. This is visible as soon as the current track crosses the boundary, with no clock edge needed. A software-reset bit that sticks, or that disturbs the stored fields, shows up one cycle later as a second pulse or as changed codes.

// File: rtl/fdc_rate_pkg.sv
package fdc_rate_pkg;

  typedef enum logic [1:0] {
    RATE_500K = 2'b00,
    RATE_300K = 2'b01,
    RATE_250K = 2'b10,
    RATE_2M   = 2'b11
  } rate_e;

  // Control byte layout: rate in [1:0], precomp in [4:2], spare [5],
  // power-down [6], reset request [7].
  typedef struct packed {
    logic       srst_req;
    logic       pwr_dn;
    logic       spare;
    logic [2:0] pcode;
    rate_e      rate;
  } ctl_byte_t;

  localparam logic [7:0] CTL_RST_VAL = 8'h02;

endpackage

// File: rtl/fdc_rst_sync.sv
module fdc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fdc_ctl_reg.sv
module fdc_ctl_reg
  import fdc_rate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dsr_we,
  input  logic [7:0] dsr_wdata,
  input  logic       ccr_we,
  input  logic [1:0] ccr_rate,
  output rate_e      rate_q,
  output logic [2:0] pcode_q,
  output logic       pwr_dn_q,
  output logic       srst_pulse_q
);
  ctl_byte_t wr_byte;
  ctl_byte_t rst_byte;
  rate_e      rate_d;
  logic [2:0] pcode_d;
  logic       pwr_dn_d;
  logic       srst_pulse_d;
  logic       rate_en;
  logic       cfg_en;

  assign wr_byte  = ctl_byte_t'(dsr_wdata);
  assign rst_byte = ctl_byte_t'(CTL_RST_VAL);
  assign rate_en  = dsr_we | ccr_we;
  assign cfg_en   = dsr_we;

  always_comb begin
    rate_d       = rate_q;
    pcode_d      = pcode_q;
    pwr_dn_d     = pwr_dn_q;
    srst_pulse_d = 1'b0;
    if (ccr_we) rate_d = rate_e'(ccr_rate);
    if (dsr_we) begin
      rate_d       = wr_byte.rate;
      pcode_d      = wr_byte.pcode;
      pwr_dn_d     = wr_byte.pwr_dn;
      srst_pulse_d = wr_byte.srst_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q   <= rst_byte.rate;
      pcode_q  <= rst_byte.pcode;
      pwr_dn_q <= rst_byte.pwr_dn;
    end else begin
      if (rate_en) rate_q <= rate_d;
      if (cfg_en) begin
        pcode_q  <= pcode_d;
        pwr_dn_q <= pwr_dn_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) srst_pulse_q <= 1'b0;
    else        srst_pulse_q <= srst_pulse_d;
  end

  // R4: a pulse only follows a write that requested it
  p_pulse_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    srst_pulse_q |-> $past(dsr_we && dsr_wdata[7]));

  // R3: control byte beats a simultaneous configuration-control write
  p_dsr_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dsr_we && ccr_we) |=> (rate_q == rate_e'($past(dsr_wdata[1:0]))));
endmodule

// File: rtl/fdc_trk_cfg.sv
module fdc_trk_cfg #(
  parameter int TRK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [TRK_W-1:0] cfg_start_trk,
  input  logic [TRK_W-1:0] cur_trk,
  output logic [TRK_W-1:0] start_q,
  output logic             trk_en
);
  logic [TRK_W-1:0] start_d;

  always_comb begin
    start_d = start_q;
    if (cfg_we) start_d = cfg_start_trk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      start_q <= '0;
    else if (cfg_we) start_q <= start_d;
  end

  assign trk_en = (cur_trk >= start_q);

  // R9: start track only moves on a configure write
  p_start_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(start_q));
endmodule

// File: rtl/fdc_precomp_sel.sv
module fdc_precomp_sel
  import fdc_rate_pkg::*;
#(
  parameter int TICK_W    = 4,
  parameter int SLOW_STEP = 2,
  parameter int FAST_STEP = 1,
  parameter int SLOW_DFLT = 6,
  parameter int FAST_DFLT = 2
) (
  input  rate_e             rate,
  input  logic [2:0]        pcode,
  input  logic              enable,
  output logic [TICK_W-1:0] ticks
);
  localparam int NCODES  = 8;
  localparam int OFF_CODE = NCODES - 1;

  logic [TICK_W-1:0] slow_tbl [NCODES];
  logic [TICK_W-1:0] fast_tbl [NCODES];
  logic [TICK_W-1:0] raw_ticks;

  for (genvar g = 0; g < NCODES; g++) begin : g_tbl
    if (g == 0) begin : g_dflt
      assign slow_tbl[g] = TICK_W'(SLOW_DFLT);
      assign fast_tbl[g] = TICK_W'(FAST_DFLT);
    end else if (g == OFF_CODE) begin : g_off
      assign slow_tbl[g] = '0;
      assign fast_tbl[g] = '0;
    end else begin : g_step
      assign slow_tbl[g] = TICK_W'(g * SLOW_STEP);
      assign fast_tbl[g] = TICK_W'(g * FAST_STEP);
    end
  end

  always_comb begin
    if (rate == RATE_2M) raw_ticks = fast_tbl[pcode];
    else                 raw_ticks = slow_tbl[pcode];
    ticks = enable ? raw_ticks : '0;
  end

  // R6: the fast-rate delay never exceeds the slow-rate delay for a code
  always_comb begin
    if (enable && rate == RATE_2M)
      a_fast_le_slow_r6: assert (fast_tbl[pcode] <= slow_tbl[pcode]);
  end
endmodule

// File: rtl/fdc_rate_precomp.sv
module fdc_rate_precomp
  import fdc_rate_pkg::*;
#(
  parameter int TRK_W     = 8,
  parameter int TICK_W    = 4,
  parameter int SLOW_STEP = 2,
  parameter int FAST_STEP = 1,
  parameter int SLOW_DFLT = 6,
  parameter int FAST_DFLT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dsr_we,
  input  logic [7:0]        dsr_wdata,
  input  logic              ccr_we,
  input  logic [1:0]        ccr_rate,
  input  logic              cfg_we,
  input  logic [TRK_W-1:0]  cfg_start_trk,
  input  logic [TRK_W-1:0]  cur_trk,
  output logic [1:0]        rate_sel,
  output logic [2:0]        precomp_code,
  output logic              power_down,
  output logic              soft_rst_pulse,
  output logic [TICK_W-1:0] precomp_ticks
);
  logic             rst_sync_n;
  rate_e            rate_q;
  logic [2:0]       pcode_q;
  logic             pwr_dn_q;
  logic [TRK_W-1:0] start_q;
  logic             trk_en;
  logic             delay_en;

  fdc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  fdc_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_sync_n),
    .dsr_we(dsr_we), .dsr_wdata(dsr_wdata),
    .ccr_we(ccr_we), .ccr_rate(ccr_rate),
    .rate_q(rate_q), .pcode_q(pcode_q), .pwr_dn_q(pwr_dn_q),
    .srst_pulse_q(soft_rst_pulse));

  fdc_trk_cfg #(.TRK_W(TRK_W)) u_trk (
    .clk(clk), .rst_n(rst_sync_n),
    .cfg_we(cfg_we), .cfg_start_trk(cfg_start_trk), .cur_trk(cur_trk),
    .start_q(start_q), .trk_en(trk_en));

  assign delay_en = trk_en & ~pwr_dn_q;

  fdc_precomp_sel #(
    .TICK_W(TICK_W), .SLOW_STEP(SLOW_STEP), .FAST_STEP(FAST_STEP),
    .SLOW_DFLT(SLOW_DFLT), .FAST_DFLT(FAST_DFLT)
  ) u_sel (
    .rate(rate_q), .pcode(pcode_q), .enable(delay_en), .ticks(precomp_ticks));

  assign rate_sel     = rate_q;
  assign precomp_code = pcode_q;
  assign power_down   = pwr_dn_q;

  p_pd_zero_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    power_down |-> (precomp_ticks == '0));

  p_trk_gate_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cur_trk < start_q) |-> (precomp_ticks == '0));

  p_rate_hold_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!dsr_we && !ccr_we) |=> $stable(rate_sel));

  p_code_off_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (precomp_code == 3'b111) |-> (precomp_ticks == '0));

  p_ccr_load_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ccr_we && !dsr_we) |=> (rate_sel == $past(ccr_rate)));
endmodule

// File: tb/test_fdc_rate_precomp.sv
module test_fdc_rate_precomp;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       dsr_we;
  logic [7:0] dsr_wdata;
  logic       ccr_we;
  logic [1:0] ccr_rate;
  logic       cfg_we;
  logic [7:0] cfg_start_trk;
  logic [7:0] cur_trk;
  logic [1:0] rate_sel;
  logic [2:0] precomp_code;
  logic       power_down;
  logic       soft_rst_pulse;
  logic [3:0] precomp_ticks;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdc_rate_precomp i_fdc_rate_precomp (
    .clk(clk), .rst_n(rst_n),
    .dsr_we(dsr_we), .dsr_wdata(dsr_wdata),
    .ccr_we(ccr_we), .ccr_rate(ccr_rate),
    .cfg_we(cfg_we), .cfg_start_trk(cfg_start_trk), .cur_trk(cur_trk),
    .rate_sel(rate_sel), .precomp_code(precomp_code), .power_down(power_down),
    .soft_rst_pulse(soft_rst_pulse), .precomp_ticks(precomp_ticks));

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_ticks(input int rate, input int code);
    if (code == 7) return 0;
    if (rate == 3) return (code == 0) ? 2 : code;
    return (code == 0) ? 6 : 2 * code;
  endfunction

  task automatic wr_dsr(input logic [7:0] d);
    @(negedge clk); dsr_we = 1'b1; dsr_wdata = d;
    @(negedge clk); dsr_we = 1'b0;
  endtask

  task automatic wr_ccr(input logic [1:0] r);
    @(negedge clk); ccr_we = 1'b1; ccr_rate = r;
    @(negedge clk); ccr_we = 1'b0;
  endtask

  task automatic wr_cfg(input logic [7:0] t);
    @(negedge clk); cfg_we = 1'b1; cfg_start_trk = t;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; dsr_we = 1'b0; dsr_wdata = '0; ccr_we = 1'b0; ccr_rate = '0;
    cfg_we = 1'b0; cfg_start_trk = '0; cur_trk = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 rate", rate_sel, 2);
    chk("R1 code", precomp_code, 0);
    chk("R1 pd", power_down, 0);
    chk("R1 pulse", soft_rst_pulse, 0);
    chk("R1 ticks", precomp_ticks, 6);

    // R2/R5/R6/R8 sweep over rate, code, power-down and spare bit 5
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 8; c++)
        for (int p = 0; p < 2; p++)
          for (int s = 0; s < 2; s++) begin
            wr_dsr({1'b0, p[0], s[0], c[2:0], r[1:0]});
            chk("R2 rate", rate_sel, r);
            chk("R2 code", precomp_code, c);
            chk("R2 pd", power_down, p);
            if (p == 1) chk("R8 ticks", precomp_ticks, 0);
            else if (r == 3) chk("R6 ticks", precomp_ticks, exp_ticks(r, c));
            else chk("R5 ticks", precomp_ticks, exp_ticks(r, c));
          end

    // R7/R9 track gating, slow rate code 3
    wr_dsr(8'h0D);
    wr_cfg(8'd5);
    for (int t = 0; t <= 10; t++) begin
      cur_trk = t[7:0];
      #1;
      chk("R7 gate", precomp_ticks, (t >= 5) ? 6 : 0);
    end
    repeat (3) @(negedge clk);
    cur_trk = 8'd4; #1;
    chk("R9 start held", precomp_ticks, 0);
    wr_cfg(8'hFF);
    wr_dsr(8'h17);
    cur_trk = 8'hFE; #1;
    chk("R7 below top", precomp_ticks, 0);
    cur_trk = 8'hFF; #1;
    chk("R7 at top", precomp_ticks, 5);
    wr_cfg(8'd0);
    cur_trk = 8'd0; #1;
    chk("R9 start zero", precomp_ticks, 5);

    // R3 last writer wins
    wr_dsr(8'h00);
    wr_ccr(2'b11);
    chk("R3 ccr rate", rate_sel, 3);
    chk("R3 ccr code kept", precomp_code, 0);
    chk("R3 ccr ticks", precomp_ticks, 2);
    wr_dsr(8'h01);
    chk("R3 dsr after ccr", rate_sel, 1);
    repeat (4) @(negedge clk);
    chk("R3 hold", rate_sel, 1);
    @(negedge clk);
    dsr_we = 1'b1; dsr_wdata = 8'h0C; ccr_we = 1'b1; ccr_rate = 2'b10;
    @(negedge clk);
    dsr_we = 1'b0; ccr_we = 1'b0;
    chk("R3 same cycle rate", rate_sel, 0);
    chk("R3 same cycle ticks", precomp_ticks, 6);

    // R4 software reset pulse
    wr_dsr(8'h8D);
    chk("R4 pulse high", soft_rst_pulse, 1);
    chk("R4 rate", rate_sel, 1);
    chk("R4 code", precomp_code, 3);
    @(negedge clk);
    chk("R4 pulse low", soft_rst_pulse, 0);
    repeat (4) @(negedge clk);
    chk("R4 rate kept", rate_sel, 1);
    chk("R4 code kept", precomp_code, 3);
    chk("R4 pd kept", power_down, 0);
    chk("R4 ticks kept", precomp_ticks, 6);
    wr_dsr(8'h0D);
    chk("R4 no pulse", soft_rst_pulse, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule